// File: doc/BRIEF.md
# Time-Division Slot Sequencer

This block gathers five upstream streams of a measurement pipeline and writes their values, one 32-bit word at a time, onto a single write port that feeds a DMA engine. The five sources are: a phase value, a raw sample, a filtered sample, a demodulated I/Q pair and a filtered I/Q pair. Each I/Q beat carries I in its low half and Q in its high half. The write port runs much faster than the pipeline produces data, so the sources can share one port in a fixed rotating order without falling behind.

A round has fourteen slots, made of two passes of seven: a reference pass and then a sample pass. Each pass visits phase, raw, filtered, I/Q-I, I/Q-Q, filtered-I/Q-I and filtered-I/Q-Q, in that order. Slot i is controlled by bit i of a mask. When the bit is clear, the slot's value is still taken from its stream but is not written. This keeps every stream in step no matter which slots are captured.

The sequencer runs only while the DMA side reports that it is waiting for data. At all other times the slot position is held at zero and an active-low reset is driven to the processing pipeline. An overflow flag reports each word that was written while the downstream port reported that it was full.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: Reset is synchronous on `rst_n` low. At the edge after it, `wr_en`, `overflow` and `proc_rst_n` are 0, and the next round starts at slot 0.
- R2: While `dma_waiting` is 0, no stream sees `tready` high, nothing is written, and `proc_rst_n` is 0 from the following cycle on.
- R3: Slot indices run 0..13, and each index modulo 7 selects phase, raw, filtered, I/Q-I, I/Q-Q, filtered-I/Q-I or filtered-I/Q-Q, in that order. The slot advances by one per accepted value and wraps from 13 to 0.
- R4: An I slot writes bits 31:0 of the current I/Q beat and does not raise that stream's `tready`. The following Q slot writes bits 63:32 of the same beat and raises `tready`, so one beat serves two slots.
- R5: Bit i of `slot_en` enables slot i, with bit 0 being the reference-pass phase slot. A disabled slot still gives its stream a handshake but produces no write.
- R6: At most one `tready` is high in any cycle. A slot whose stream has `tvalid` low holds its position and writes nothing.
- R7: `wr_en` and `wr_data` are registered. A value accepted in cycle n appears on the port in cycle n+1, at most one word per clock.
- R8: `overflow` is high in cycle n+1 exactly when `wr_en` and `wr_full` are both high in cycle n.
- R9: When `dma_waiting` falls partway through a round, the sequencer returns to slot 0. The first word after it rises again comes from the reference phase slot.
- R10: `proc_rst_n` goes high one cycle after `dma_waiting` is seen high outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_waiting | input | 1 | DMA side is waiting for data; enables the sequencer |
| slot_en | input | 14 | Per-slot write enable, bit i for slot i |
| phase_tdata | input | 32 | Phase stream data |
| phase_tvalid | input | 1 | Phase stream valid |
| phase_tready | output | 1 | Phase stream ready |
| raw_tdata | input | 32 | Raw sample stream data |
| raw_tvalid | input | 1 | Raw sample stream valid |
| raw_tready | output | 1 | Raw sample stream ready |
| filt_tdata | input | 32 | Filtered sample stream data |
| filt_tvalid | input | 1 | Filtered sample stream valid |
| filt_tready | output | 1 | Filtered sample stream ready |
| iq_tdata | input | 64 | I/Q stream, I in 31:0, Q in 63:32 |
| iq_tvalid | input | 1 | I/Q stream valid |
| iq_tready | output | 1 | I/Q stream ready |
| fiq_tdata | input | 64 | Filtered I/Q stream, I in 31:0, Q in 63:32 |
| fiq_tvalid | input | 1 | Filtered I/Q stream valid |
| fiq_tready | output | 1 | Filtered I/Q stream ready |
| wr_en | output | 1 | Write strobe to the DMA port |
| wr_data | output | 32 | Write data to the DMA port |
| wr_full | input | 1 | Downstream port cannot take the current word |
| overflow | output | 1 | A word was written while the port was full |
| proc_rst_n | output | 1 | Active-low reset to the processing pipeline |

## Verification
Two things can coincide: the DMA side can stop waiting in the very cycle a slot accepts a value, and a write can be posted while `wr_full` is high. The bench provokes both by toggling `dma_waiting` and `wr_full` pseudo-randomly while the streams present data with random gaps and the mask changes. A behavioural reference model tracks the slot index, the stream handshakes and the expected port words. On every clock it judges whether a late accept still produced its write, whether the slot restarted at zero, and whether each word written into a full port raised exactly one overflow cycle.

// File: rtl/tss_pkg.sv
package tss_pkg;

   localparam int unsigned KINDS_PER_PASS = 7;
   localparam int unsigned NUM_SRC        = 5;

   typedef enum logic [2:0] {
      K_PH    = 3'd0,
      K_RAW   = 3'd1,
      K_FILT  = 3'd2,
      K_IQ_I  = 3'd3,
      K_IQ_Q  = 3'd4,
      K_FIQ_I = 3'd5,
      K_FIQ_Q = 3'd6
   } slot_kind_e;

   // stream index serving a slot kind
   function automatic int unsigned kind_src(slot_kind_e k);
      case (k)
         K_PH:           return 0;
         K_RAW:          return 1;
         K_FILT:         return 2;
         K_IQ_I, K_IQ_Q: return 3;
         default:        return 4;
      endcase
   endfunction

   // slot takes the upper half of a wide beat
   function automatic logic kind_upper(slot_kind_e k);
      return (k == K_IQ_Q) || (k == K_FIQ_Q);
   endfunction

   // slot completes the stream handshake
   function automatic logic kind_pops(slot_kind_e k);
      return (k != K_IQ_I) && (k != K_FIQ_I);
   endfunction

endpackage

// File: rtl/tss_slot_counter.sv
module tss_slot_counter
   import tss_pkg::*;
#(
   parameter  int unsigned PASSES    = 2,
   localparam int unsigned NUM_SLOTS = PASSES * KINDS_PER_PASS,
   localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
   localparam int unsigned PASS_W    = (PASSES > 1) ? $clog2(PASSES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              advance,
   output slot_kind_e        kind,
   output logic [SLOT_W-1:0] slot
);

   slot_kind_e        kind_q;
   logic [PASS_W-1:0] pass_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         kind_q <= K_PH;
         pass_q <= '0;
      end else if (advance) begin
         if (kind_q == K_FIQ_Q) begin
            kind_q <= K_PH;
            pass_q <= (int'(pass_q) == PASSES - 1) ? '0 : pass_q + 1'b1;
         end else begin
            kind_q <= slot_kind_e'(kind_q + 3'd1);
         end
      end
   end

   assign kind = kind_q;
   assign slot = SLOT_W'(int'(pass_q) * KINDS_PER_PASS + int'(kind_q));

endmodule

// File: rtl/tss_router.sv
module tss_router
   import tss_pkg::*;
#(
   parameter  int unsigned DATA_W = 32,
   localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
   input  logic                               active,
   input  slot_kind_e                         kind,
   input  logic [NUM_SRC-1:0]                 src_valid,
   input  logic [NUM_SRC-1:0][2*DATA_W-1:0]   src_data,
   output logic [NUM_SRC-1:0]                 src_ready,
   output logic                               sel_valid,
   output logic [DATA_W-1:0]                  sel_data
);

   logic [SRC_W-1:0] src_idx;
   logic             upper;
   logic             pops;

   always_comb begin
      src_idx = SRC_W'(kind_src(kind));
      upper   = kind_upper(kind);
      pops    = kind_pops(kind);
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_ready
      assign src_ready[s] = active && pops && (src_idx == SRC_W'(s));
   end

   assign sel_valid = src_valid[src_idx];
   assign sel_data  = upper ? src_data[src_idx][2*DATA_W-1:DATA_W]
                            : src_data[src_idx][DATA_W-1:0];

endmodule

// File: rtl/tss_write_stage.sv
module tss_write_stage #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              keep,
   input  logic [DATA_W-1:0] data_in,
   input  logic              wr_full,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              overflow
);

   logic              en_q;
   logic [DATA_W-1:0] data_q;
   logic              ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         data_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         en_q  <= take && keep;
         ovf_q <= en_q && wr_full;
         if (take && keep) data_q <= data_in;
      end
   end

   assign wr_en    = en_q;
   assign wr_data  = data_q;
   assign overflow = ovf_q;

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
   import tss_pkg::*;
#(
   parameter  int unsigned DATA_W       = 32,
   parameter  int unsigned PASSES       = 2,
   parameter  bit          PIPE_RST_REG = 1'b1,
   localparam int unsigned NUM_SLOTS    = PASSES * KINDS_PER_PASS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dma_waiting,
   input  logic [NUM_SLOTS-1:0] slot_en,
   input  logic [DATA_W-1:0]    phase_tdata,
   input  logic                 phase_tvalid,
   output logic                 phase_tready,
   input  logic [DATA_W-1:0]    raw_tdata,
   input  logic                 raw_tvalid,
   output logic                 raw_tready,
   input  logic [DATA_W-1:0]    filt_tdata,
   input  logic                 filt_tvalid,
   output logic                 filt_tready,
   input  logic [2*DATA_W-1:0]  iq_tdata,
   input  logic                 iq_tvalid,
   output logic                 iq_tready,
   input  logic [2*DATA_W-1:0]  fiq_tdata,
   input  logic                 fiq_tvalid,
   output logic                 fiq_tready,
   output logic                 wr_en,
   output logic [DATA_W-1:0]    wr_data,
   input  logic                 wr_full,
   output logic                 overflow,
   output logic                 proc_rst_n
);

   localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);

   if (DATA_W < 1 || PASSES < 1) begin : g_bad_params
      $error("tdm_slot_sequencer: DATA_W and PASSES must be at least 1");
   end

   logic                             active;
   slot_kind_e                       kind;
   logic [SLOT_W-1:0]                slot;
   logic [NUM_SRC-1:0]               src_valid;
   logic [NUM_SRC-1:0]               src_ready;
   logic [NUM_SRC-1:0][2*DATA_W-1:0] src_data;
   logic                             sel_valid;
   logic [DATA_W-1:0]                sel_data;
   logic                             take;

   assign active = rst_n && dma_waiting;
   assign take   = active && sel_valid;

   assign src_valid = {fiq_tvalid, iq_tvalid, filt_tvalid, raw_tvalid, phase_tvalid};
   assign src_data[0] = {{DATA_W{1'b0}}, phase_tdata};
   assign src_data[1] = {{DATA_W{1'b0}}, raw_tdata};
   assign src_data[2] = {{DATA_W{1'b0}}, filt_tdata};
   assign src_data[3] = iq_tdata;
   assign src_data[4] = fiq_tdata;

   assign phase_tready = src_ready[0];
   assign raw_tready   = src_ready[1];
   assign filt_tready  = src_ready[2];
   assign iq_tready    = src_ready[3];
   assign fiq_tready   = src_ready[4];

   tss_slot_counter #(.PASSES(PASSES)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (dma_waiting),
      .advance (take),
      .kind    (kind),
      .slot    (slot)
   );

   tss_router #(.DATA_W(DATA_W)) u_route (
      .active    (active),
      .kind      (kind),
      .src_valid (src_valid),
      .src_data  (src_data),
      .src_ready (src_ready),
      .sel_valid (sel_valid),
      .sel_data  (sel_data)
   );

   tss_write_stage #(.DATA_W(DATA_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .keep     (slot_en[slot]),
      .data_in  (sel_data),
      .wr_full  (wr_full),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .overflow (overflow)
   );

   if (PIPE_RST_REG) begin : g_prst_reg
      logic prst_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prst_q <= 1'b0;
         else        prst_q <= dma_waiting;
      end
      assign proc_rst_n = prst_q;
   end else begin : g_prst_comb
      assign proc_rst_n = active;
   end

endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
   parameter int unsigned NUM_SLOTS = 14,
   parameter int unsigned SLOT_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dma_waiting,
   input logic [4:0]        rdy,
   input logic              wr_en,
   input logic              wr_full,
   input logic              overflow,
   input logic              proc_rst_n,
   input logic [SLOT_W-1:0] slot
);

   p_idle_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_waiting |-> (rdy == 5'd0));

   p_idle_holds_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_waiting |=> !proc_rst_n);

   p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(slot) < NUM_SLOTS);

   p_one_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rdy));

   p_write_after_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(dma_waiting));

   p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_full) |=> overflow);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_full) |=> !overflow);

   p_restart_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_waiting |=> (slot == '0));

   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_waiting |=> proc_rst_n);

endmodule

bind tdm_slot_sequencer tss_checker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W($clog2(NUM_SLOTS))) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dma_waiting (dma_waiting),
   .rdy         ({fiq_tready, iq_tready, filt_tready, raw_tready, phase_tready}),
   .wr_en       (wr_en),
   .wr_full     (wr_full),
   .overflow    (overflow),
   .proc_rst_n  (proc_rst_n),
   .slot        (u_cnt.slot)
);

// File: tb/tdm_slot_sequencer_bench.sv
module tdm_slot_sequencer_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n       = 1'b0;
   logic              dma_waiting = 1'b0;
   logic              wr_full     = 1'b0;
   logic [13:0]       slot_en     = '1;
   logic [4:0]        vld         = '0;
   logic [4:0][63:0]  dat         = '0;
   logic [4:0]        rdy;
   logic              wr_en, overflow, proc_rst_n;
   logic [31:0]       wr_data;

   tdm_slot_sequencer u_tdm_slot_sequencer (
      .clk(clk), .rst_n(rst_n), .dma_waiting(dma_waiting), .slot_en(slot_en),
      .phase_tdata(dat[0][31:0]), .phase_tvalid(vld[0]), .phase_tready(rdy[0]),
      .raw_tdata(dat[1][31:0]),   .raw_tvalid(vld[1]),   .raw_tready(rdy[1]),
      .filt_tdata(dat[2][31:0]),  .filt_tvalid(vld[2]),  .filt_tready(rdy[2]),
      .iq_tdata(dat[3]),          .iq_tvalid(vld[3]),    .iq_tready(rdy[3]),
      .fiq_tdata(dat[4]),         .fiq_tvalid(vld[4]),   .fiq_tready(rdy[4]),
      .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
      .overflow(overflow), .proc_rst_n(proc_rst_n)
   );

   int          errors = 0;
   int          checks = 0;
   int          p_valid = 100;
   int          p_full  = 0;
   int          p_wait  = -1;
   int          m_slot = 0;
   bit          e_wr_en = 1'b0;
   logic [31:0] e_wr_data = '0;
   bit          e_ovf = 1'b0;
   bit          e_prst = 1'b0;
   logic [4:0]  hs = '0;
   int          hs_count = 0;
   int          ovf_count = 0;
   int          cnt [5] = '{0, 0, 0, 0, 0};
   logic [31:0] obs [$];

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   // tag nibbles: phase 1, raw 2, filt 3, I/Q I 4, Q 5, filtered I 6, Q 7
   function automatic logic [63:0] mk(input int s, input int c);
      case (s)
         0: return {32'h0, 4'h1, 28'(c)};
         1: return {32'h0, 4'h2, 28'(c)};
         2: return {32'h0, 4'h3, 28'(c)};
         3: return {4'h5, 28'(c), 4'h4, 28'(c)};
         default: return {4'h7, 28'(c), 4'h6, 28'(c)};
      endcase
   endfunction

   // one clock: evaluate the model on current inputs, clock, compare, refresh sources
   task automatic cycle();
      bit         act, pops, up, fire, n_wr, n_ovf;
      int         kind, src;
      logic [4:0] e_rdy;
      #1;
      act  = rst_n && dma_waiting;
      kind = m_slot % 7;
      src  = (kind < 3) ? kind : ((kind < 5) ? 3 : 4);
      pops = (kind < 3) || (kind == 4) || (kind == 6);
      up   = (kind == 4) || (kind == 6);
      e_rdy = '0;
      if (act && pops) e_rdy[src] = 1'b1;
      check(rdy === e_rdy, "R6 ready vector", 64'(rdy), 64'(e_rdy));
      fire = act && vld[src];
      hs   = e_rdy & vld;
      hs_count += $countones(hs);
      if (!rst_n) begin
         n_wr = 1'b0; n_ovf = 1'b0; e_prst = 1'b0; m_slot = 0;
      end else begin
         n_ovf  = e_wr_en && wr_full;
         e_prst = dma_waiting;
         n_wr   = fire && slot_en[m_slot];
         if (n_wr) e_wr_data = up ? dat[src][63:32] : dat[src][31:0];
         if (!dma_waiting) m_slot = 0;
         else if (fire)    m_slot = (m_slot + 1) % 14;
      end
      e_wr_en = n_wr;
      e_ovf   = n_ovf;
      @(posedge clk);
      @(negedge clk);
      check(wr_en === e_wr_en, "R7 wr_en", 64'(wr_en), 64'(e_wr_en));
      if (e_wr_en) check(wr_data === e_wr_data, "R4 wr_data", 64'(wr_data), 64'(e_wr_data));
      check(overflow === e_ovf, "R8 overflow", 64'(overflow), 64'(e_ovf));
      check(proc_rst_n === e_prst, "R10 proc_rst_n", 64'(proc_rst_n), 64'(e_prst));
      if (wr_en) obs.push_back(wr_data);
      if (overflow) ovf_count++;
      for (int s = 0; s < 5; s++) begin
         if (hs[s]) begin vld[s] = 1'b0; cnt[s]++; end
         if (!vld[s] && int'($urandom % 100) < p_valid) begin
            vld[s] = 1'b1;
            dat[s] = mk(s, cnt[s]);
         end
      end
      wr_full = int'($urandom % 100) < p_full;
      if (p_wait >= 0) dma_waiting = int'($urandom % 100) < p_wait;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic check_round(input string tag);
      logic [3:0] exp_tag;
      check(obs.size() == 14, {tag, " word count"}, 64'(obs.size()), 64'd14);
      for (int i = 0; i < 14 && i < obs.size(); i++) begin
         exp_tag = 4'((i % 7) + 1);
         check(obs[i][31:28] == exp_tag, {tag, " slot order"}, 64'(obs[i][31:28]), 64'(exp_tag));
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // R1: reset state
      rst_n = 1'b0; dma_waiting = 1'b1; p_valid = 100;
      run(3);
      check(wr_en === 1'b0, "R1 wr_en in reset", 64'(wr_en), 64'd0);
      check(overflow === 1'b0, "R1 overflow in reset", 64'(overflow), 64'd0);
      check(proc_rst_n === 1'b0, "R1 proc_rst_n in reset", 64'(proc_rst_n), 64'd0);

      // R2: idle keeps everything still
      dma_waiting = 1'b0; rst_n = 1'b1; hs_count = 0; obs.delete();
      run(10);
      check(hs_count == 0, "R2 no handshake while idle", 64'(hs_count), 64'd0);
      check(obs.size() == 0, "R2 no write while idle", 64'(obs.size()), 64'd0);
      check(proc_rst_n === 1'b0, "R2 pipeline held in reset", 64'(proc_rst_n), 64'd0);

      // R3 / R7: full round, all enabled, all valid
      dma_waiting = 1'b1; obs.delete();
      cycle();
      check(obs.size() == 1, "R7 first word one cycle after accept", 64'(obs.size()), 64'd1);
      check(proc_rst_n === 1'b1, "R10 release after waiting", 64'(proc_rst_n), 64'd1);
      run(13);
      check_round("R3 first round");
      obs.delete();
      run(14);
      check_round("R3 wrapped round");

      // R5: masks, with gaps on the streams
      p_valid = 40; slot_en = 14'h2AAA;
      run(400);
      slot_en = 14'h0000; obs.delete(); hs_count = 0;
      run(200);
      check(obs.size() == 0, "R5 all slots masked", 64'(obs.size()), 64'd0);
      check(hs_count > 0, "R5 masked slots still consumed", 64'(hs_count), 64'd1);
      slot_en = 14'h0001; run(200);
      slot_en = 14'h2000; run(200);
      slot_en = 14'h1555; run(200);

      // R8: writes into a full port
      slot_en = '1; p_valid = 70; p_full = 50; ovf_count = 0;
      run(300);
      check(ovf_count > 0, "R8 overflow seen", 64'(ovf_count), 64'd1);
      p_full = 0;

      // R9: stop partway through a round
      p_valid = 100; run(5);
      dma_waiting = 1'b0; cycle();
      dma_waiting = 1'b1; obs.delete();
      run(3);
      check(obs.size() > 0 && obs[0][31:28] == 4'h1, "R9 restart at phase slot",
            64'(obs.size() > 0 ? obs[0][31:28] : 4'h0), 64'd1);

      // R2 / R9 / R8: waiting and full toggling together
      p_valid = 60; p_full = 30; p_wait = 70;
      run(1500);
      p_wait = -1; p_full = 0; dma_waiting = 1'b1;
      run(50);

      // R1: reset in the middle of traffic
      rst_n = 1'b0; run(2);
      check(wr_en === 1'b0 && proc_rst_n === 1'b0, "R1 mid-run reset",
            64'({wr_en, proc_rst_n}), 64'd0);
      rst_n = 1'b1; run(30);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule